// File: doc/BRIEF.md
# I2C Master Host Register Bank

This block is the software-visible front of a byte-oriented I2C master. A host drives a small synchronous port: a 3-bit byte address, 8-bit write data and a write strobe, with read data returned combinationally from the addressed register. Behind the bank sits a separate transfer engine that shifts bits on the wire. The bank hands that engine a 16-bit clock divider, an enable, the byte to transmit, single-cycle command pulses and an acknowledge level for reads. The engine reports back a received byte, whether the last byte got a NACK, arbitration loss, bus activity and byte completion.

Location 4 is shared. A write there is a command whose action bits are turned into one-cycle pulses and never stored for readback. A read there returns status. Completion of a byte, or loss of arbitration, raises a sticky flag that only the command acknowledge bit clears. A level interrupt follows that flag while the interrupt enable in the control byte is set.

Top module: `i2cm_regbank`

## Requirements
- R1: After reset every readable location returns 0x00, and the interrupt, command pulses, divider, enable, transmit byte and acknowledge level outputs are all 0.
- R2: Address 0 holds the divider low byte, 1 the divider high byte, 2 the control byte and 3 the transmit byte on write. Reads of 0 to 2 return the stored byte. Writes to addresses 5 to 7 change nothing, and reads of them return 0x00.
- R3: `eng_prescale` equals {byte 1, byte 0}, `eng_enable` equals control bit 7, and `eng_txdata` equals the last byte written to address 3.
- R4: A write to address 4 while control bit 7 is 1 raises `eng_start`, `eng_stop`, `eng_read` and `eng_write` for exactly the cycle after the write, from command bits 7, 6, 5 and 4. Reading address 4 never returns these bits.
- R5: Command bit 3 of an accepted command is latched onto `eng_ack_lvl` (1 means a NACK is sent after the read byte) and held until the next accepted command.
- R6: While control bit 7 is 0, writes to address 4 produce no pulse, do not set the in-progress bit and do not clear the interrupt flag.
- R7: Status bit 1 (in progress) is 1 from the cycle after an accepted command with bit 5 or bit 4 set. It clears on `eng_done`. If both happen in the same cycle, the bit stays set.
- R8: Status bit 0 (interrupt flag) is set by `eng_done` or `eng_arblost` and is cleared by an accepted command with bit 0 set. If a set and a clear happen in the same cycle, the flag stays set.
- R9: Status bit 7 takes `eng_rxnack` at each `eng_done`. Status bit 5 is set by `eng_arblost` and cleared by an accepted command with bit 7 set. Status bit 6 is `eng_busy` delayed by one cycle. Status bits 4 to 2 read as 0.
- R10: Reading address 3 returns the `eng_rxdata` byte captured at the last `eng_done`, not the transmit byte.
- R11: `irq` is 1 exactly while the interrupt flag and control bit 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Byte address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | Start-condition pulse |
| eng_stop | output | 1 | Stop-condition pulse |
| eng_read | output | 1 | Read-byte pulse |
| eng_write | output | 1 | Write-byte pulse |
| eng_ack_lvl | output | 1 | Acknowledge level for reads, 1 = NACK |
| eng_txdata | output | 8 | Byte to transmit |
| eng_prescale | output | 16 | Bit clock divider |
| eng_enable | output | 1 | Core enable |
| eng_rxdata | input | 8 | Received byte, valid with eng_done |
| eng_rxnack | input | 1 | Last byte not acknowledged, valid with eng_done |
| eng_arblost | input | 1 | Arbitration lost |
| eng_busy | input | 1 | Bus busy |
| eng_done | input | 1 | Byte operation finished |

## Verification
Every stored value, command pulse and status bit changes at the clock edge that samples the write or engine event. The bench therefore drives inputs on the falling edge and samples at the next falling edge, half a cycle after that one register stage. The pulse checks also look one cycle later to confirm the pulse has dropped. Reads are combinational, so the bench sets the address on a falling edge and samples a nanosecond later. `irq` is derived from registered bits, so it is due in the same cycle as the status change that drives it. Random host and engine events are checked against a bench model of every register. Directed cases add a completion in the same cycle as a command, and commands sent while the core is disabled.

// File: rtl/i2cm_regbank_pkg.sv
package i2cm_regbank_pkg;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int NCFG   = 4;
    localparam int PRE_W  = 2 * DW;

    localparam logic [AW-1:0] A_PRE_LO  = AW'(0);
    localparam logic [AW-1:0] A_PRE_HI  = AW'(1);
    localparam logic [AW-1:0] A_CTRL    = AW'(2);
    localparam logic [AW-1:0] A_DATA    = AW'(3);
    localparam logic [AW-1:0] A_CMDSTAT = AW'(4);

    localparam int CTL_EN  = 7;
    localparam int CTL_IEN = 6;

    localparam int CMD_STA  = 7;
    localparam int CMD_STO  = 6;
    localparam int CMD_RD   = 5;
    localparam int CMD_WR   = 4;
    localparam int CMD_ACK  = 3;
    localparam int CMD_IACK = 0;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
        logic ack;
        logic iack;
    } cmd_fields_t;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
    } cmd_pulse_t;

    typedef struct packed {
        logic          tip;
        logic          iflag;
        logic          al;
        logic          rxnack;
        logic          busy;
        logic [DW-1:0] rx;
    } stat_t;
endpackage

// File: rtl/i2cm_cfg_regs.sv
module i2cm_cfg_regs
    import i2cm_regbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [NCFG-1:0][DW-1:0]  bank
);
    logic [NCFG-1:0]           we;
    logic [NCFG-1:0][DW-1:0]   bank_d, bank_q;

    for (genvar g = 0; g < NCFG; g++) begin : g_we
        assign we[g] = wr_en && (addr == AW'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NCFG; i++) begin
            if (we[i]) bank_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank = bank_q;
endmodule

// File: rtl/i2cm_cmd_ctrl.sv
module i2cm_cmd_ctrl
    import i2cm_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [AW-1:0] addr,
    input  cmd_fields_t cmd,
    input  logic        core_en,
    output cmd_pulse_t  pulse,
    output logic        ack_lvl,
    output logic        acc_rdwr,
    output logic        acc_sta,
    output logic        acc_iack
);
    typedef struct packed {
        cmd_pulse_t pulse;
        logic       ack;
    } cmd_state_t;

    cmd_state_t st_d, st_q;
    logic       accept;

    assign accept   = wr_en && (addr == A_CMDSTAT) && core_en;
    assign acc_rdwr = accept && (cmd.rd || cmd.wr);
    assign acc_sta  = accept && cmd.sta;
    assign acc_iack = accept && cmd.iack;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        if (accept) begin
            st_d.pulse.sta = cmd.sta;
            st_d.pulse.sto = cmd.sto;
            st_d.pulse.rd  = cmd.rd;
            st_d.pulse.wr  = cmd.wr;
            st_d.ack       = cmd.ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse   = st_q.pulse;
    assign ack_lvl = st_q.ack;
endmodule

// File: rtl/i2cm_stat_track.sv
module i2cm_stat_track
    import i2cm_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_tip,
    input  logic          clr_if,
    input  logic          clr_al,
    input  logic          done,
    input  logic          arblost,
    input  logic          rxnack,
    input  logic          busy,
    input  logic [DW-1:0] rxdata,
    output stat_t         stat
);
    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy;
        if (done) begin
            st_d.rx     = rxdata;
            st_d.rxnack = rxnack;
        end
        if (set_tip)   st_d.tip = 1'b1;
        else if (done) st_d.tip = 1'b0;
        if (done || arblost) st_d.iflag = 1'b1;
        else if (clr_if)     st_d.iflag = 1'b0;
        if (arblost)     st_d.al = 1'b1;
        else if (clr_al) st_d.al = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q;
endmodule

// File: rtl/i2cm_regbank.sv
module i2cm_regbank
    import i2cm_regbank_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   host_addr,
    input  logic         host_wr,
    input  logic [7:0]   host_wdata,
    output logic [7:0]   host_rdata,
    output logic         irq,
    output logic         eng_start,
    output logic         eng_stop,
    output logic         eng_read,
    output logic         eng_write,
    output logic         eng_ack_lvl,
    output logic [7:0]   eng_txdata,
    output logic [15:0]  eng_prescale,
    output logic         eng_enable,
    input  logic [7:0]   eng_rxdata,
    input  logic         eng_rxnack,
    input  logic         eng_arblost,
    input  logic         eng_busy,
    input  logic         eng_done
);
    logic [NCFG-1:0][DW-1:0] bank;
    cmd_fields_t             cmd;
    cmd_pulse_t              pulse;
    stat_t                   stat;
    logic                    acc_rdwr, acc_sta, acc_iack;
    logic                    ctrl_ien, tip_now, if_now;
    logic [DW-1:0]           stat_byte;

    i2cm_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr),
        .addr  (host_addr),
        .wdata (host_wdata),
        .bank  (bank)
    );

    always_comb begin
        cmd.sta  = host_wdata[CMD_STA];
        cmd.sto  = host_wdata[CMD_STO];
        cmd.rd   = host_wdata[CMD_RD];
        cmd.wr   = host_wdata[CMD_WR];
        cmd.ack  = host_wdata[CMD_ACK];
        cmd.iack = host_wdata[CMD_IACK];
    end

    i2cm_cmd_ctrl u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .addr     (host_addr),
        .cmd      (cmd),
        .core_en  (eng_enable),
        .pulse    (pulse),
        .ack_lvl  (eng_ack_lvl),
        .acc_rdwr (acc_rdwr),
        .acc_sta  (acc_sta),
        .acc_iack (acc_iack)
    );

    i2cm_stat_track u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_tip (acc_rdwr),
        .clr_if  (acc_iack),
        .clr_al  (acc_sta),
        .done    (eng_done),
        .arblost (eng_arblost),
        .rxnack  (eng_rxnack),
        .busy    (eng_busy),
        .rxdata  (eng_rxdata),
        .stat    (stat)
    );

    assign eng_prescale = {bank[A_PRE_HI], bank[A_PRE_LO]};
    assign eng_enable   = bank[A_CTRL][CTL_EN];
    assign ctrl_ien     = bank[A_CTRL][CTL_IEN];
    assign eng_txdata   = bank[A_DATA];
    assign eng_start    = pulse.sta;
    assign eng_stop     = pulse.sto;
    assign eng_read     = pulse.rd;
    assign eng_write    = pulse.wr;

    assign tip_now   = stat.tip;
    assign if_now    = stat.iflag;
    assign stat_byte = {stat.rxnack, stat.busy, stat.al, 3'b000, tip_now, if_now};
    assign irq       = if_now & ctrl_ien;

    always_comb begin
        case (host_addr)
            A_PRE_LO:  host_rdata = bank[A_PRE_LO];
            A_PRE_HI:  host_rdata = bank[A_PRE_HI];
            A_CTRL:    host_rdata = bank[A_CTRL];
            A_DATA:    host_rdata = stat.rx;
            A_CMDSTAT: host_rdata = stat_byte;
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cm_regbank_chk.sv
module i2cm_regbank_chk
    import i2cm_regbank_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] host_addr,
    input logic          host_wr,
    input logic          w_sta,
    input logic          w_rd,
    input logic          w_wr,
    input logic          eng_start,
    input logic          eng_stop,
    input logic          eng_read,
    input logic          eng_write,
    input logic          eng_enable,
    input logic          eng_done,
    input logic          eng_arblost,
    input logic          irq,
    input logic          ctrl_ien,
    input logic          tip_now,
    input logic          if_now
);
    logic cmd_wr, rdwr_acc;
    assign cmd_wr   = host_wr && (host_addr == A_CMDSTAT);
    assign rdwr_acc = cmd_wr && eng_enable && (w_rd || w_wr);

    // R4
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(cmd_wr && eng_enable && w_sta));

    // R4
    write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_write |-> $past(cmd_wr && eng_enable && w_wr));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !eng_enable) |=> !(eng_start || eng_stop || eng_read || eng_write));

    // R7
    tip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdwr_acc |=> tip_now);

    // R7
    tip_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !rdwr_acc) |=> !tip_now);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done || eng_arblost) |=> if_now);

    // R11
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && ctrl_ien && !(host_wr && host_addr == A_CTRL)) |=> irq);
endmodule

bind i2cm_regbank i2cm_regbank_chk chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .w_sta       (host_wdata[7]),
    .w_rd        (host_wdata[5]),
    .w_wr        (host_wdata[4]),
    .eng_start   (eng_start),
    .eng_stop    (eng_stop),
    .eng_read    (eng_read),
    .eng_write   (eng_write),
    .eng_enable  (eng_enable),
    .eng_done    (eng_done),
    .eng_arblost (eng_arblost),
    .irq         (irq),
    .ctrl_ien    (ctrl_ien),
    .tip_now     (tip_now),
    .if_now      (if_now)
);

// File: tb/i2cm_regbank_test.sv
`timescale 1ns/1ps
module i2cm_regbank_test;
    logic clk = 0, rst_n = 0;
    logic [2:0] host_addr = 0;
    logic host_wr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic irq, eng_start, eng_stop, eng_read, eng_write, eng_ack_lvl, eng_enable;
    logic [7:0] eng_txdata, eng_rxdata = 0;
    logic [15:0] eng_prescale;
    logic eng_rxnack = 0, eng_arblost = 0, eng_busy = 0, eng_done = 0;

    always #2.5 clk = ~clk;

    i2cm_regbank uut (.*);

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_cfg [4];
    logic [7:0] m_rx;
    logic m_tip, m_if, m_al, m_nack, m_busy, m_ack;
    logic [3:0] seen;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(int a);
        case (a)
            0, 1, 2: return m_cfg[a];
            3: return m_rx;
            4: return {m_nack, m_busy, m_al, 3'b000, m_tip, m_if};
            default: return 8'h00;
        endcase
    endfunction

    task automatic host_write(int a, logic [7:0] d, string req);
        logic [3:0] ep;
        @(negedge clk); host_addr = a[2:0]; host_wdata = d; host_wr = 1;
        @(posedge clk);
        @(negedge clk);
        seen = {eng_start, eng_stop, eng_read, eng_write};
        host_wr = 0;
        ep = 4'h0;
        if (a < 4) m_cfg[a] = d;
        else if (a == 4 && m_cfg[2][7]) begin
            ep = d[7:4];
            m_ack = d[3];
            if (d[5] | d[4]) m_tip = 1;
            if (d[0]) m_if = 0;
            if (d[7]) m_al = 0;
        end
        chk(req, seen, ep);
    endtask

    task automatic engine(logic done, logic arb, logic nack, logic [7:0] rx);
        @(negedge clk); eng_done = done; eng_arblost = arb; eng_rxnack = nack; eng_rxdata = rx;
        @(posedge clk);
        @(negedge clk); eng_done = 0; eng_arblost = 0;
        if (arb) begin m_al = 1; m_if = 1; end
        if (done) begin m_tip = 0; m_if = 1; m_rx = rx; m_nack = nack; end
    endtask

    task automatic set_busy(logic b);
        @(negedge clk); eng_busy = b;
        @(posedge clk); m_busy = b;
    endtask

    task automatic check_all(string req);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); host_addr = a[2:0]; #1;
            chk(req, host_rdata, exp_read(a));
        end
        chk(req, eng_prescale, {m_cfg[1], m_cfg[0]});
        chk(req, eng_enable, m_cfg[2][7]);
        chk(req, eng_txdata, m_cfg[3]);
        chk(req, eng_ack_lvl, m_ack);
        chk(req, irq, m_if & m_cfg[2][6]);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1c2a));
        for (int i = 0; i < 4; i++) m_cfg[i] = 0;
        m_rx = 0; m_tip = 0; m_if = 0; m_al = 0; m_nack = 0; m_busy = 0; m_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        check_all("R1");
        chk("R1", {eng_start, eng_stop, eng_read, eng_write}, 0);
        // R2 R3 configuration bytes
        host_write(0, 8'h3c, "R2");
        host_write(1, 8'ha5, "R2");
        host_write(3, 8'h77, "R3");
        check_all("R3");
        // R6 commands while disabled
        host_write(4, 8'hf1, "R6");
        check_all("R6");
        engine(1, 0, 0, 8'h5a);
        host_write(4, 8'h01, "R6");
        check_all("R6");
        // R11 enable interrupts: flag already set
        host_write(2, 8'hc0, "R11");
        chk("R11", irq, 1);
        // R8 acknowledge clears flag
        host_write(4, 8'h01, "R8");
        check_all("R8");
        // R4 start+write pulse, single cycle
        host_write(4, 8'h90, "R4");
        @(negedge clk);
        chk("R4", {eng_start, eng_stop, eng_read, eng_write}, 0);
        check_all("R7");
        // R5 read with NACK level
        host_write(4, 8'h28, "R5");
        chk("R5", eng_ack_lvl, 1);
        // R9 R10 completion with NACK
        engine(1, 0, 1, 8'h3e);
        check_all("R10");
        engine(0, 1, 0, 8'h00);
        check_all("R9");
        set_busy(1);
        check_all("R9");
        // R7 R8 done in same cycle as write+iack: set wins
        @(negedge clk); host_addr = 4; host_wdata = 8'h11; host_wr = 1;
        eng_done = 1; eng_rxdata = 8'hc3; eng_rxnack = 0;
        @(posedge clk);
        @(negedge clk); host_wr = 0; eng_done = 0;
        m_rx = 8'hc3; m_nack = 0; m_tip = 1; m_if = 1; m_ack = 0;
        check_all("R7");
        // R2 unmapped addresses ignored
        host_write(6, 8'hff, "R2");
        host_write(5, 8'h81, "R2");
        check_all("R2");
        // random mix
        for (int it = 0; it < 400; it++) begin
            case ($urandom % 6)
                0: host_write($urandom % 8, 8'($urandom), "R2");
                1: host_write(4, 8'($urandom), "R4");
                2: engine(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
                3: set_busy(1'($urandom));
                4: host_write(2, {1'b1, 7'($urandom)}, "R3");
                default: check_all("R9");
            endcase
        end
        check_all("R11");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule